// File: doc/BRIEF.md
# Polyphase Coefficient RAM Loader

This block fills a two-bank polyphase scaler coefficient RAM from a coefficient table. The datapath reads one bank, the active bank. The loader writes the other bank, the shadow bank. A filter with 64 phases is symmetric, so only its 33 unique phases (0 to 32) are written. Each RAM word carries a pair of taps. Once every word of a changed set has been accepted, the active-bank select flips, and the new coefficients take effect in a single step.

A request is a one-cycle `load_req` pulse. It carries a tap count, a filter-type code, a set identifier and a flag that selects the fixed bilinear 2-tap mode. The table is read through two combinational read ports, one for the even tap and one for the odd tap of the current pair. Coefficient words leave on a valid/ready stream. `wr_valid` stays high for the whole load. A word is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the address and data are held steady, and the loader waits for as long as the sink needs. Requests that call for no writes complete at once with `done`, or with `err` for a malformed request, and neither bank changes.

Top module: `coef_ram_loader`

## Requirements
- R1: After reset, `active_bank`, `wr_valid`, `done` and `err` are all 0.
- R2: A load emits 33 × ceil(taps/2) words. Phases 0 to 32 go in ascending order, and pairs ascend within each phase. `wr_addr` is {filter type [10:8], phase [7:2], pair [1:0]}.
- R3: Bits [15:0] of `wr_data` hold the even slot, which is tap 2p. Bits [31:16] hold the odd slot, which is tap 2p+1, or zero when 2p+1 ≥ taps. Both slots have their two least significant bits forced to 0.
- R4: The table is indexed by phase × taps + tap. The even port reads tap 2p and the odd port reads tap 2p+1 of the current pair.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` keep their values on the next cycle.
- R6: Writes target `wr_bank`, the inverse of `active_bank`. In the cycle after the last word is accepted, `done` pulses for one cycle and `active_bank` has inverted. `active_bank` changes at no other time.
- R7: A request with `hardcode_2tap` set gives `done` with no writes and no bank change.
- R8: A request with taps = 1 gives `done` with no writes and no bank change.
- R9: A tap count of 0 or greater than 8, or a filter-type code above 5, makes `err` pulse. Such a request gives no `done`, no writes and no bank change. The valid type codes are 0 to 5, for luma, chroma and alpha, each vertical then horizontal.
- R10: A request whose {set id, taps, type} matches the last completed load gives `done` with no writes and no bank change. A request that differs in any of those fields is loaded.
- R11: `load_req` is ignored while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_req | input | 1 | One-cycle request pulse |
| taps | input | 4 | Tap count of the requested filter |
| filt_type | input | 3 | Filter-type code, 0 to 5 |
| set_id | input | 8 | Identifier of the coefficient set |
| hardcode_2tap | input | 1 | Fixed bilinear mode: no table is needed |
| src_addr_even | output | 9 | Table index of the even tap |
| src_addr_odd | output | 9 | Table index of the odd tap |
| src_even | input | 16 | Table value at `src_addr_even` |
| src_odd | input | 16 | Table value at `src_addr_odd` |
| wr_valid | output | 1 | A coefficient word is offered |
| wr_ready | input | 1 | The sink accepts the word |
| wr_addr | output | 11 | RAM word address |
| wr_data | output | 32 | Packed tap pair, odd slot in the upper half |
| wr_bank | output | 1 | Bank being written (the shadow bank) |
| active_bank | output | 1 | Bank the datapath reads |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The assertions take for granted that the table read ports are combinational. For a held address they return a held value, so the hold check on stalled words relies on it. The bench supplies such a table, computed as a fixed function of the index. It varies `wr_ready` with several stall patterns, from always ready to long gaps. The bench issues requests only while the loader is idle. The one exception is the deliberate pulse that checks R11.

// File: rtl/coef_ldr_pkg.sv
package coef_ldr_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_LOAD = 1'b1} ldr_state_e;
endpackage

// File: rtl/coef_ldr_ctrl.sv
module coef_ldr_ctrl
  import coef_ldr_pkg::*;
#(
  parameter int TAP_W     = 4,
  parameter int TYPE_W    = 3,
  parameter int ID_W      = 8,
  parameter int MAX_TAPS  = 8,
  parameter int NUM_TYPES = 6,
  localparam int KEY_W    = ID_W + TAP_W + TYPE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [TAP_W-1:0]  taps,
  input  logic [TYPE_W-1:0] filt_type,
  input  logic [ID_W-1:0]   set_id,
  input  logic              hardcode_2tap,
  input  logic              fire,
  input  logic              final_word,
  output logic              loading,
  output logic              start,
  output logic [TAP_W-1:0]  taps_q,
  output logic [TYPE_W-1:0] type_q,
  output logic              active_bank,
  output logic              done,
  output logic              err
);
  ldr_state_e       state;
  logic [ID_W-1:0]  id_q;
  logic [KEY_W-1:0] last_key;
  logic             last_vld;
  logic             bad_req, skip_req, accept;

  assign loading  = (state == ST_LOAD);
  assign accept   = load_req && (state == ST_IDLE);
  assign bad_req  = (taps == '0) || (taps > TAP_W'(MAX_TAPS))
                 || (filt_type >= TYPE_W'(NUM_TYPES));
  assign skip_req = (taps == TAP_W'(1)) || hardcode_2tap
                 || (last_vld && (last_key == {set_id, taps, filt_type}));
  assign start    = accept && !bad_req && !skip_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      taps_q      <= '0;
      type_q      <= '0;
      id_q        <= '0;
      active_bank <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      last_vld    <= 1'b0;
      last_key    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        if (bad_req) begin
          err <= 1'b1;
        end else if (skip_req) begin
          done <= 1'b1;
        end else begin
          state  <= ST_LOAD;
          taps_q <= taps;
          type_q <= filt_type;
          id_q   <= set_id;
        end
      end else if (loading && fire && final_word) begin
        state       <= ST_IDLE;
        done        <= 1'b1;
        active_bank <= ~active_bank;
        last_vld    <= 1'b1;
        last_key    <= {id_q, taps_q, type_q};
      end
    end
  end
endmodule

// File: rtl/coef_ldr_walk.sv
module coef_ldr_walk #(
  parameter int TAP_W  = 4,
  parameter int PH_W   = 6,
  parameter int PAIR_W = 2,
  parameter int SRC_W  = 9,
  parameter int UNIQ_PH = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [TAP_W-1:0]  taps_q,
  output logic [PH_W-1:0]   phase,
  output logic [PAIR_W-1:0] pair,
  output logic              final_word,
  output logic              odd_present,
  output logic [SRC_W-1:0]  src_addr_even,
  output logic [SRC_W-1:0]  src_addr_odd
);
  logic [TAP_W-1:0] npairs;
  logic             last_pair, last_phase;
  logic [SRC_W-1:0] base;

  assign npairs      = TAP_W'(taps_q + TAP_W'(1)) >> 1;
  assign last_pair   = (pair == PAIR_W'(npairs - TAP_W'(1)));
  assign last_phase  = (phase == PH_W'(UNIQ_PH - 1));
  assign final_word  = last_pair && last_phase;
  assign odd_present = TAP_W'({pair, 1'b1}) < taps_q;

  assign base          = SRC_W'(phase) * SRC_W'(taps_q);
  assign src_addr_even = base + SRC_W'({pair, 1'b0});
  assign src_addr_odd  = src_addr_even + SRC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pair  <= '0;
    end else if (start) begin
      phase <= '0;
      pair  <= '0;
    end else if (advance) begin
      if (last_pair) begin
        pair  <= '0;
        phase <= phase + PH_W'(1);
      end else begin
        pair <= pair + PAIR_W'(1);
      end
    end
  end
endmodule

// File: rtl/coef_ldr_pack.sv
module coef_ldr_pack #(
  parameter int COEF_W = 16
) (
  input  logic [COEF_W-1:0]   src_even,
  input  logic [COEF_W-1:0]   src_odd,
  input  logic                odd_present,
  output logic [2*COEF_W-1:0] word
);
  logic [COEF_W-1:0] raw  [2];
  logic              keep [2];

  assign raw[0]  = src_even;
  assign raw[1]  = src_odd;
  assign keep[0] = 1'b1;
  assign keep[1] = odd_present;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign word[s*COEF_W +: COEF_W] = keep[s] ? {raw[s][COEF_W-1:2], 2'b00} : '0;
  end
endmodule

// File: rtl/coef_ram_loader.sv
module coef_ram_loader #(
  parameter int COEF_W     = 16,
  parameter int MAX_TAPS   = 8,
  parameter int NUM_PHASES = 64,
  parameter int TYPE_W     = 3,
  parameter int NUM_TYPES  = 6,
  parameter int ID_W       = 8,
  localparam int UNIQ_PH   = NUM_PHASES / 2 + 1,
  localparam int PH_W      = $clog2(UNIQ_PH),
  localparam int PAIR_W    = (MAX_TAPS / 2 > 1) ? $clog2(MAX_TAPS / 2) : 1,
  localparam int TAP_W     = $clog2(MAX_TAPS + 1),
  localparam int SRC_W     = $clog2(UNIQ_PH * MAX_TAPS),
  localparam int ADDR_W    = TYPE_W + PH_W + PAIR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_req,
  input  logic [TAP_W-1:0]    taps,
  input  logic [TYPE_W-1:0]   filt_type,
  input  logic [ID_W-1:0]     set_id,
  input  logic                hardcode_2tap,
  output logic [SRC_W-1:0]    src_addr_even,
  output logic [SRC_W-1:0]    src_addr_odd,
  input  logic [COEF_W-1:0]   src_even,
  input  logic [COEF_W-1:0]   src_odd,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [2*COEF_W-1:0] wr_data,
  output logic                wr_bank,
  output logic                active_bank,
  output logic                done,
  output logic                err
);
  logic              loading, start, fire, final_word, odd_present;
  logic [TAP_W-1:0]  taps_q;
  logic [TYPE_W-1:0] type_q;
  logic [PH_W-1:0]   phase;
  logic [PAIR_W-1:0] pair;

  assign wr_valid = loading;
  assign fire     = loading && wr_ready;
  assign wr_addr  = {type_q, phase, pair};
  assign wr_bank  = ~active_bank;

  coef_ldr_ctrl #(
    .TAP_W(TAP_W), .TYPE_W(TYPE_W), .ID_W(ID_W),
    .MAX_TAPS(MAX_TAPS), .NUM_TYPES(NUM_TYPES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .taps(taps),
    .filt_type(filt_type), .set_id(set_id), .hardcode_2tap(hardcode_2tap),
    .fire(fire), .final_word(final_word), .loading(loading), .start(start),
    .taps_q(taps_q), .type_q(type_q), .active_bank(active_bank),
    .done(done), .err(err)
  );

  coef_ldr_walk #(
    .TAP_W(TAP_W), .PH_W(PH_W), .PAIR_W(PAIR_W), .SRC_W(SRC_W), .UNIQ_PH(UNIQ_PH)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(fire), .taps_q(taps_q),
    .phase(phase), .pair(pair), .final_word(final_word),
    .odd_present(odd_present), .src_addr_even(src_addr_even),
    .src_addr_odd(src_addr_odd)
  );

  coef_ldr_pack #(.COEF_W(COEF_W)) u_pack (
    .src_even(src_even), .src_odd(src_odd), .odd_present(odd_present),
    .word(wr_data)
  );
endmodule

// File: rtl/coef_ram_loader_chk.sv
module coef_ram_loader_chk #(
  parameter int COEF_W  = 16,
  parameter int ADDR_W  = 11,
  parameter int PH_W    = 6,
  parameter int PAIR_W  = 2,
  parameter int UNIQ_PH = 33
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [2*COEF_W-1:0] wr_data,
  input logic                wr_bank,
  input logic                active_bank,
  input logic                done,
  input logic                err
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_lsb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[1:0] == 2'b00 && wr_data[COEF_W+1:COEF_W] == 2'b00));

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[PAIR_W+PH_W-1:PAIR_W] < PH_W'(UNIQ_PH)));

  assert_shadow_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_bank != active_bank));

  assert_swap_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_bank) |-> done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  assert_err_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !wr_valid));
endmodule

bind coef_ram_loader coef_ram_loader_chk #(
  .COEF_W(COEF_W), .ADDR_W(ADDR_W), .PH_W(PH_W), .PAIR_W(PAIR_W), .UNIQ_PH(UNIQ_PH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_bank(wr_bank),
  .active_bank(active_bank), .done(done), .err(err)
);

// File: tb/tb_coef_ram_loader.sv
module tb_coef_ram_loader;
  localparam int CLK_PERIOD = 10;
  localparam int ITEM_W = 11 + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_req = 1'b0;
  logic [3:0]  taps = '0;
  logic [2:0]  filt_type = '0;
  logic [7:0]  set_id = '0;
  logic        hardcode_2tap = 1'b0;
  logic [8:0]  src_addr_even, src_addr_odd;
  logic [15:0] src_even, src_odd;
  logic        wr_valid, wr_bank, active_bank, done, err;
  logic        wr_ready = 1'b1;
  logic [10:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0, errors = 0, cyc = 0, stall_mode = 0;
  int writes_seen = 0;
  bit done_seen = 0, err_seen = 0;
  logic [ITEM_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_ram_loader dut (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .taps(taps),
    .filt_type(filt_type), .set_id(set_id), .hardcode_2tap(hardcode_2tap),
    .src_addr_even(src_addr_even), .src_addr_odd(src_addr_odd),
    .src_even(src_even), .src_odd(src_odd), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bank(wr_bank), .active_bank(active_bank), .done(done), .err(err)
  );

  function automatic logic [15:0] tbl(input int a);
    return 16'((a * 40503 + 4660) ^ (a << 5));
  endfunction

  // R4: the table model answers at the index the loader asks for
  always_comb src_even = tbl(int'(src_addr_even));
  always_comb src_odd  = tbl(int'(src_addr_odd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // ready pattern, changed away from both clock edges
  always @(posedge clk) begin
    #2;
    case (stall_mode)
      1:       wr_ready = (cyc % 3) != 0;
      2:       wr_ready = (cyc % 7) < 2;
      default: wr_ready = 1'b1;
    endcase
  end

  // monitor: pops the scoreboard for each accepted word
  always @(negedge clk) begin
    if (done) done_seen = 1;
    if (err)  err_seen  = 1;
    if (rst_n && wr_valid && wr_ready) begin
      writes_seen++;
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected word", int'(wr_addr), -1);
      end else begin
        logic [ITEM_W-1:0] e;
        e = exp_q.pop_front();
        check(wr_addr == e[42:32], "R2 address", int'(wr_addr), int'(e[42:32]));
        check(wr_data == e[31:0], "R3 data", int'(wr_data), int'(e[31:0]));
        check(wr_bank == ~active_bank, "R6 shadow bank", int'(wr_bank), int'(~active_bank));
      end
    end
  end

  // kind: 0 load, 1 complete without writes, 2 rejected
  task automatic run_load(input int t, input int ty, input int id, input bit hc,
                          input int kind, input bit inject);
    logic bank0;
    int   n = 0;
    int   npairs = (t + 1) / 2;
    bank0 = active_bank;
    if (kind == 0) begin
      for (int ph = 0; ph < 33; ph++) begin
        for (int p = 0; p < npairs; p++) begin
          logic [15:0] ev, od;
          ev = tbl(ph * t + 2 * p) & 16'hFFFC;
          od = (2 * p + 1 < t) ? (tbl(ph * t + 2 * p + 1) & 16'hFFFC) : 16'h0;
          exp_q.push_back({3'(ty), 6'(ph), 2'(p), od, ev});
        end
      end
    end
    @(negedge clk);
    writes_seen = 0; done_seen = 0; err_seen = 0;
    taps = 4'(t); filt_type = 3'(ty); set_id = 8'(id); hardcode_2tap = hc;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    if (inject) begin
      repeat (7) @(negedge clk);
      taps = 4'd8; filt_type = 3'd0; set_id = 8'd99; load_req = 1'b1;
      @(negedge clk);
      load_req = 1'b0;
      taps = 4'(t); filt_type = 3'(ty); set_id = 8'(id);
    end
    while (!done_seen && !err_seen && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    if (kind == 0) begin
      check(done_seen && !err_seen, "R6 done after load", int'(done_seen), 1);
      check(writes_seen == 33 * npairs, "R2 word count", writes_seen, 33 * npairs);
      check(exp_q.size() == 0, "R2 words missing", exp_q.size(), 0);
      check(active_bank == ~bank0, "R6 bank flipped", int'(active_bank), int'(~bank0));
    end else if (kind == 1) begin
      check(done_seen && !err_seen, "R7 R8 R10 done without load", int'(done_seen), 1);
      check(writes_seen == 0, "R7 R8 R10 no words", writes_seen, 0);
      check(active_bank == bank0, "R7 R8 R10 bank kept", int'(active_bank), int'(bank0));
    end else begin
      check(err_seen && !done_seen, "R9 err without done", int'(err_seen), 1);
      check(writes_seen == 0, "R9 no words", writes_seen, 0);
      check(active_bank == bank0, "R9 bank kept", int'(active_bank), int'(bank0));
    end
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(active_bank == 1'b0, "R1 active_bank", int'(active_bank), 0);
    check(wr_valid == 1'b0, "R1 wr_valid", int'(wr_valid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(err == 1'b0, "R1 err", int'(err), 0);

    stall_mode = 0; run_load(4, 1, 1, 0, 0, 0);   // R2 R3 R4, always ready
    stall_mode = 1; run_load(5, 0, 2, 0, 0, 0);   // R3 odd slot zeroed, R5 stalls
    stall_mode = 2; run_load(8, 3, 3, 0, 0, 0);   // R5 long stalls, full taps
    stall_mode = 0; run_load(8, 3, 3, 0, 1, 0);   // R10 repeat of last set
    run_load(2, 4, 4, 1, 1, 0);                   // R7 fixed bilinear mode
    run_load(1, 1, 7, 0, 1, 0);                   // R8 single tap
    run_load(0, 1, 8, 0, 2, 0);                   // R9 zero taps
    run_load(9, 1, 8, 0, 2, 0);                   // R9 too many taps
    run_load(4, 6, 8, 0, 2, 0);                   // R9 bad type code
    stall_mode = 1; run_load(3, 5, 5, 0, 0, 1);   // R11 request during load ignored
    stall_mode = 0; run_load(2, 2, 6, 0, 0, 0);   // R2 two taps without hardcode
    run_load(4, 2, 6, 0, 0, 0);                   // R10 same id, new taps, loads
    run_load(4, 2, 9, 0, 0, 0);                   // R10 new id only, loads
    finish_run();
  end
endmodule